// File: doc/BRIEF.md
# Programmable Local Countdown Timer

This block is the timer source of a local interrupt controller. Software sets three things: a divide setting, a start value and a timer entry. The entry holds an interrupt vector, a mask bit and a periodic bit. Each time the divided bus clock ticks, the count drops by one. When the count reaches zero, the block records one expiry in a small pending counter.

A recorded expiry goes out on the request output, together with the vector, only while three conditions hold: the controller is enabled in hardware, the controller is enabled in software, and the entry is unmasked. While any of these conditions fails, expiries stay in the pending counter. Software can read the remaining count at any time.

The bus clock reaches the block as a clock-enable strobe, `base_tick`. All register access uses one synchronous write port and one synchronous read port.

Top module: `loc_timer`

## Requirements
- R1: After reset, the registers read back as follows: entry (select 0) `0x0001_0000`, so only the mask bit is set; divide (select 1) 0; start value (select 2) 0; current count (select 3) 0; control (select 4) `0xFF`, so software enable is off. `irq_valid` is low.
- R2: The divide register keeps bits 3, 1 and 0 of a write; bit 2 reads as 0. The divisor is D = 1 << ((({bit3,bit1,bit0}) + 1) mod 8). Code 000 gives /2, 011 gives /16, 100 gives /32, and 111 gives /1.
- R3: A write of N (non-zero) to the start value (select 2) begins a countdown of N×D `base_tick` cycles. With `base_tick` held high, `irq_valid` first rises N×D+1 clock cycles after the write edge, provided delivery is allowed.
- R4: A start value of 0 stops the timer. The current count then reads 0 and no expiry occurs.
- R5: Select 3 reads the remaining `base_tick` cycles of the present period divided by D. The read value drops by one every D ticks.
- R6: When entry bit 17 (periodic) is set, the count reloads the start value on the cycle of expiry and keeps running. When bit 17 is clear, the count stops at 0 and reads 0 until the next start-value write.
- R7: Each expiry adds one to a pending counter. One pending expiry is delivered per cycle, as a one-cycle `irq_valid` with `irq_vector` equal to entry bits 7:0. Delivery requires `hw_enable`, control bit 8 (software enable) and entry bit 16 (mask) clear. The counter decreases only on a delivery.
- R8: A control write with bit 8 clear sets the entry mask bit and empties the pending counter. While bit 8 is clear, every entry write is stored with the mask bit forced to 1.
- R9: An entry write keeps only bits 7:0, 12, 16 and 17. All other bits read back as 0.
- R10: A start-value write during a running count empties the pending counter and restarts the countdown from the new value.
- R11: A divide write during a running count does not restart it. The new divisor applies from the next prescaler boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Bus-cycle clock enable for the prescaler |
| hw_enable | input | 1 | Hardware enable of the controller |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write register select (0 entry, 1 divide, 2 start value, 4 control) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Read register select (3 = current count) |
| rd_data | output | 32 | Registered read data, valid one cycle after `rd_sel` |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The bench measures the expiry latency from a start-value write for several divide codes. These include the /1 and /2 ends, a code with the high split bit set, and a code with only the ignored bit 2 set. Together they separate a correct field split and wrap from a plain binary decode.

The bench samples the current count mid-run. It does so with the divisor fixed and again with the divisor changed mid-count, which shows whether a divide write restarts the count or applies at once instead of at a boundary.

Delivery is held back in turn by `hw_enable`, by the mask and by software disable. The bench checks that held expiries are counted and later released, and that a disable or a start-value write discards them.

Periodic runs are compared with one-shot runs, and the periodic run is stopped on the very edge of an expiry.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int DATA_W      = 32;
  localparam int VEC_W       = 8;
  localparam int SHIFT_W     = 3;
  localparam int PRE_W       = (1 << SHIFT_W) - 1;
  localparam int DIV_W       = 4;
  localparam int CTRL_W      = 9;
  localparam int ENT_STAT_BIT = 12;
  localparam int ENT_MASK_BIT = 16;
  localparam int ENT_PER_BIT  = 17;
  localparam int CTRL_EN_BIT  = 8;

  localparam logic [DATA_W-1:0] ENT_KEEP   = 32'h0003_10FF;
  localparam logic [DATA_W-1:0] ENT_RESET  = 32'h0001_0000;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h0FF;
  localparam logic [DIV_W-1:0]  DIV_KEEP   = 4'b1011;

  typedef enum logic [2:0] {
    SEL_ENTRY = 3'd0,
    SEL_DIV   = 3'd1,
    SEL_INIT  = 3'd2,
    SEL_CURR  = 3'd3,
    SEL_CTRL  = 3'd4
  } sel_e;

  // Split field {b3,b1,b0} plus one, wrapping: 111 -> shift 0 (divide by 1)
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIV_W-1:0] code);
    logic [SHIFT_W-1:0] packed_code;
    packed_code = {code[3], code[1:0]};
    return packed_code + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/lt_regs.sv
module lt_regs
  import lt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_sel,
  input  logic [CNT_W-1:0]  cur_val,
  output logic [DATA_W-1:0] entry_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [CNT_W-1:0]  init_q,
  output logic              sw_en,
  output logic              load,
  output logic              clr_pend,
  output logic [DATA_W-1:0] rd_data
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] entry_d;
  logic              wr_entry, wr_div, wr_ctrl;

  assign sw_en    = ctrl_q[CTRL_EN_BIT];
  assign wr_entry = wr_en && (wr_sel == SEL_ENTRY);
  assign wr_div   = wr_en && (wr_sel == SEL_DIV);
  assign wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);
  assign load     = wr_en && (wr_sel == SEL_INIT);
  assign clr_pend = load || (wr_ctrl && !wr_data[CTRL_EN_BIT]);

  always_comb begin
    entry_d = wr_data & ENT_KEEP;
    if (!sw_en) entry_d[ENT_MASK_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_q <= ENT_RESET;
      div_q   <= '0;
      init_q  <= '0;
      ctrl_q  <= CTRL_RESET;
    end else begin
      if (wr_entry) entry_q <= entry_d;
      if (wr_div)   div_q   <= wr_data[DIV_W-1:0] & DIV_KEEP;
      if (load)     init_q  <= wr_data[CNT_W-1:0];
      if (wr_ctrl) begin
        ctrl_q <= wr_data[CTRL_W-1:0];
        if (!wr_data[CTRL_EN_BIT]) entry_q[ENT_MASK_BIT] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_sel)
        SEL_ENTRY: rd_data <= entry_q;
        SEL_DIV:   rd_data <= DATA_W'(div_q);
        SEL_INIT:  rd_data <= DATA_W'(init_q);
        SEL_CURR:  rd_data <= (init_q == '0) ? '0 : DATA_W'(cur_val);
        SEL_CTRL:  rd_data <= DATA_W'(ctrl_q);
        default:   rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lt_prescaler.sv
module lt_prescaler
  import lt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               base_tick,
  input  logic               run,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift_new,
  output logic               terminal
);
  logic [PRE_W-1:0]   pre_cnt;
  logic [SHIFT_W-1:0] shift_act;
  logic [PRE_W:0]     span;
  logic [PRE_W-1:0]   limit;

  assign span     = (PRE_W+1)'(1) << shift_act;
  assign limit    = PRE_W'(span - 1'b1);
  assign terminal = base_tick && run && (pre_cnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt   <= '0;
      shift_act <= div_shift('0);
    end else if (restart) begin
      pre_cnt   <= '0;
      shift_act <= shift_new;
    end else if (base_tick && run) begin
      if (pre_cnt == limit) begin
        pre_cnt   <= '0;
        shift_act <= shift_new;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lt_downcount.sv
module lt_downcount #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             terminal,
  input  logic             periodic,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cur,
  output logic             running,
  output logic             expire
);
  assign expire = terminal && running && (cur == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cur     <= load_val;
      running <= (load_val != '0);
    end else if (terminal && running) begin
      if (cur == CNT_W'(1)) begin
        if (periodic) begin
          cur <= reload;
        end else begin
          cur     <= '0;
          running <= 1'b0;
        end
      end else begin
        cur <= cur - 1'b1;
      end
    end
  end
endmodule

// File: rtl/lt_pending.sv
module lt_pending #(
  parameter int PEND_W = 4,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              expire,
  input  logic              clr,
  input  logic              gate_ok,
  input  logic [VEC_W-1:0]  vec,
  output logic [PEND_W-1:0] pend,
  output logic              deliver,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  logic full;

  assign full    = (pend == '1);
  assign deliver = gate_ok && (pend != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else if (clr) begin
      pend <= '0;
    end else if (expire && !deliver && !full) begin
      pend <= pend + 1'b1;
    end else if (deliver && !expire) begin
      pend <= pend - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid <= deliver;
      if (deliver) irq_vector <= vec;
    end
  end
endmodule

// File: rtl/loc_timer.sv
module loc_timer
  import lt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_tick,
  input  logic              hw_enable,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [DATA_W-1:0] entry_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  init_q;
  logic [CNT_W-1:0]  cur;
  logic [PEND_W-1:0] pend_cnt;
  logic              sw_en, load, clr_pend, terminal, running, expire, deliver;
  logic              ent_mask, gate_ok;

  assign ent_mask = entry_q[ENT_MASK_BIT];
  assign gate_ok  = hw_enable && sw_en && !ent_mask;

  lt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .cur_val(cur), .entry_q(entry_q), .div_q(div_q),
    .init_q(init_q), .sw_en(sw_en), .load(load), .clr_pend(clr_pend),
    .rd_data(rd_data)
  );

  lt_prescaler u_pre (
    .clk(clk), .rst(rst), .base_tick(base_tick), .run(running),
    .restart(load), .shift_new(div_shift(div_q)), .terminal(terminal)
  );

  lt_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(wr_data[CNT_W-1:0]),
    .terminal(terminal), .periodic(entry_q[ENT_PER_BIT]), .reload(init_q),
    .cur(cur), .running(running), .expire(expire)
  );

  lt_pending #(.PEND_W(PEND_W), .VEC_W(VEC_W)) u_pend (
    .clk(clk), .rst(rst), .expire(expire), .clr(clr_pend), .gate_ok(gate_ok),
    .vec(entry_q[VEC_W-1:0]), .pend(pend_cnt), .deliver(deliver),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );
endmodule

// File: rtl/loc_timer_chk.sv
module loc_timer_chk
  import lt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              hw_enable,
  input logic              wr_en,
  input logic [2:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq_valid,
  input logic              sw_en,
  input logic              ent_mask,
  input logic [PEND_W-1:0] pend_cnt,
  input logic              expire,
  input logic              running,
  input logic              deliver,
  input logic              clr_pend,
  input logic              periodic,
  input logic [DATA_W-1:0] entry_q,
  input logic [CNT_W-1:0]  init_q
);
  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !irq_valid); // R1

  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (init_q == '0) |-> !expire); // R4

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    (expire && !periodic && !(wr_en && wr_sel == SEL_INIT)) |=> !running); // R6

  AST_DELIVER_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> $past(hw_enable && sw_en && !ent_mask && pend_cnt != '0)); // R7

  AST_PEND_DEC: assert property (@(posedge clk) disable iff (rst)
    (deliver && !expire && !clr_pend) |=> pend_cnt == PEND_W'($past(pend_cnt) - 1'b1)); // R7

  AST_PEND_INC: assert property (@(posedge clk) disable iff (rst)
    (expire && !deliver && !clr_pend && pend_cnt != '1) |=> pend_cnt == PEND_W'($past(pend_cnt) + 1'b1)); // R7

  AST_DISABLE_MASKS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_CTRL && !wr_data[CTRL_EN_BIT]) |=> (ent_mask && pend_cnt == '0)); // R8

  AST_ENTRY_BITS: assert property (@(posedge clk) disable iff (rst)
    (entry_q & ~ENT_KEEP) == '0); // R9
endmodule

bind loc_timer loc_timer_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst(rst), .hw_enable(hw_enable), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .irq_valid(irq_valid), .sw_en(sw_en), .ent_mask(ent_mask),
  .pend_cnt(pend_cnt), .expire(expire), .running(running), .deliver(deliver),
  .clr_pend(clr_pend), .periodic(entry_q[lt_pkg::ENT_PER_BIT]),
  .entry_q(entry_q), .init_q(init_q)
);

// File: tb/test_loc_timer.sv
module test_loc_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] S_ENT = 3'd0, S_DIV = 3'd1, S_INIT = 3'd2, S_CURR = 3'd3, S_CTRL = 3'd4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_tick = 1'b1;
  logic        hw_enable = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int          n_cmp = 0;
  int          n_err = 0;
  string       cur_tag = "R1";
  logic [7:0]  exp_q[$];
  logic [7:0]  popped;
  logic [31:0] rv;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loc_timer i_loc_timer (
    .clk(clk), .rst(rst), .base_tick(base_tick), .hw_enable(hw_enable),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst && irq_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++;
        n_err++;
        $display("FAIL %s: unexpected irq actual 0x%0h expected none", cur_tag, irq_vector);
      end else begin
        popped = exp_q.pop_front();
        check(cur_tag, {24'h0, irq_vector}, {24'h0, popped});
      end
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] val);
    rd_sel = sel;
    @(posedge clk);
    @(negedge clk);
    val = rd_data;
  endtask

  task automatic push(input logic [7:0] v);
    exp_q.push_back(v);
  endtask

  task automatic lat(input string tag, input int exp);
    int seen = 0;
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      if (irq_valid && seen == 0) begin
        seen = k;
        break;
      end
    end
    check(tag, seen, exp);
  endtask

  task automatic drained(input string tag);
    check(tag, exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    cur_tag = "R1";
    check("R1 irq", {31'h0, irq_valid}, 32'h0);
    rd(S_ENT, rv);  check("R1 entry", rv, 32'h0001_0000);
    rd(S_DIV, rv);  check("R1 div", rv, 32'h0);
    rd(S_INIT, rv); check("R1 init", rv, 32'h0);
    rd(S_CURR, rv); check("R1 curr", rv, 32'h0);
    rd(S_CTRL, rv); check("R1 ctrl", rv, 32'h0FF);

    // R9 entry field filtering
    cur_tag = "R9";
    wr(S_CTRL, 32'h1FF);
    wr(S_ENT, 32'hFFFF_FFFF);
    rd(S_ENT, rv); check("R9 entry keep", rv, 32'h0003_10FF);
    wr(S_ENT, 32'h0000_0041);

    // R3 latency with divide-by-1, then R6 one-shot stop
    cur_tag = "R3";
    wr(S_DIV, 32'hB);
    push(8'h41);
    wr(S_INIT, 3);
    lat("R3 latency N3 D1", 4);
    repeat (5) @(negedge clk);
    cur_tag = "R6";
    rd(S_CURR, rv); check("R6 oneshot curr", rv, 32'h0);
    drained("R6 oneshot single");

    // R2 divide decode
    cur_tag = "R2";
    wr(S_DIV, 32'h0); push(8'h41); wr(S_INIT, 3); lat("R2 code000 /2", 7);
    wr(S_DIV, 32'h3); push(8'h41); wr(S_INIT, 2); lat("R2 code011 /16", 33);
    wr(S_DIV, 32'h8); push(8'h41); wr(S_INIT, 1); lat("R2 code100 /32", 33);
    wr(S_DIV, 32'h4); push(8'h41); wr(S_INIT, 2); lat("R2 bit2 ignored /2", 5);
    rd(S_DIV, rv); check("R2 div readback", rv, 32'h0);

    // R5 current count mid-run
    cur_tag = "R5";
    wr(S_DIV, 32'h0);
    rd_sel = S_CURR;
    push(8'h41);
    wr(S_INIT, 10);
    repeat (7) @(negedge clk);
    check("R5 curr after 6 ticks", rd_data, 32'd7);
    repeat (20) @(negedge clk);
    drained("R5 expiry");

    // R11 divide change mid-count
    cur_tag = "R11";
    wr(S_ENT, 32'h0001_0041);
    rd_sel = S_CURR;
    wr(S_INIT, 100);
    repeat (4) @(negedge clk);
    wr(S_DIV, 32'hB);
    repeat (4) @(negedge clk);
    check("R11 curr after divide change", rd_data, 32'd95);

    // R4 zero start value
    cur_tag = "R4";
    wr(S_INIT, 0);
    repeat (2) @(negedge clk);
    check("R4 curr zero", rd_data, 32'h0);
    wr(S_ENT, 32'h0000_0041);
    repeat (10) @(negedge clk);
    drained("R4 no expiry");

    // R6 periodic reload, stopped on an expiry edge
    cur_tag = "R6";
    wr(S_ENT, 32'h0002_0052);
    repeat (5) push(8'h52);
    wr(S_INIT, 2);
    repeat (11) @(negedge clk);
    wr(S_INIT, 0);
    repeat (5) @(negedge clk);
    drained("R6 periodic five");

    // R7 pending buffered while hw disabled
    cur_tag = "R7";
    hw_enable = 1'b0;
    wr(S_ENT, 32'h0002_0063);
    wr(S_INIT, 4);
    repeat (9) @(negedge clk);
    wr(S_ENT, 32'h0000_0063);
    repeat (10) @(negedge clk);
    drained("R7 held while hw off");
    repeat (3) push(8'h63);
    hw_enable = 1'b1;
    repeat (6) @(negedge clk);
    drained("R7 three released");
    wr(S_ENT, 32'h0001_0063);
    wr(S_INIT, 1);
    repeat (5) @(negedge clk);
    drained("R7 held while masked");
    push(8'h63);
    wr(S_ENT, 32'h0000_0063);
    repeat (4) @(negedge clk);
    drained("R7 released on unmask");

    // R8 software disable
    cur_tag = "R8";
    wr(S_ENT, 32'h0001_0063);
    wr(S_INIT, 1);
    repeat (4) @(negedge clk);
    hw_enable = 1'b0;
    wr(S_ENT, 32'h0000_0063);
    wr(S_CTRL, 32'h0FF);
    rd(S_ENT, rv); check("R8 disable sets mask", rv, 32'h0001_0063);
    wr(S_ENT, 32'h0000_0063);
    rd(S_ENT, rv); check("R8 write forced masked", rv, 32'h0001_0063);
    wr(S_CTRL, 32'h1FF);
    wr(S_ENT, 32'h0000_0063);
    hw_enable = 1'b1;
    repeat (5) @(negedge clk);
    drained("R8 pending cleared");

    // R10 restart and pending clear on start-value write
    cur_tag = "R10";
    wr(S_ENT, 32'h0000_0074);
    wr(S_INIT, 50);
    repeat (5) @(negedge clk);
    push(8'h74);
    wr(S_INIT, 3);
    lat("R10 restart latency", 4);
    hw_enable = 1'b0;
    wr(S_INIT, 1);
    repeat (3) @(negedge clk);
    wr(S_INIT, 0);
    hw_enable = 1'b1;
    repeat (5) @(negedge clk);
    drained("R10 pending cleared");

    done = 1'b1;
    finish_run();
  end
endmodule